// File: doc/BRIEF.md
# Page-Mode Block-Read DRAM Sequencer with Open-Row Reuse

This block turns block-read requests into strobed DRAM read cycles. Each request names a row and a four-column block within that row. The controller puts the row on a shared multiplexed address bus and asserts the active-low row strobe. It then pulses the active-low column strobe four times. Before each pulse it drives the next column of the block, and it captures one data beat at the end of each pulse. After the block the row stays open: the row strobe stays low and the row address is remembered. A later request to the same row therefore goes straight to column pulses. A request to a different row first releases the row strobe for a precharge interval and then opens the new row.

Requests enter through a one-entry command buffer with a valid/ready handshake. A second request can wait in the buffer while the current block is being read. The address is driven on two buses: one carries the address true and the other carries its bitwise inverse, so each half of the memory array can take one of them. All timing intervals are parameters counted in clock cycles.

The sequencer is a five-state machine:
- `ST_IDLE`: waits for a buffered request. It goes to `ST_ROWOPEN` when no row is open, to `ST_COLSTB` on a row hit, and to `ST_PRECH` on a row miss.
- `ST_PRECH`: row strobe high for `T_RP` cycles, then goes to `ST_ROWOPEN`.
- `ST_ROWOPEN`: row strobe low with the row on the bus for `T_RCD` cycles, then goes to `ST_COLSTB`.
- `ST_COLSTB`: column strobe low for `T_CAS` cycles, then goes to `ST_COLGAP`.
- `ST_COLGAP`: column strobe high for `T_CP` cycles, then goes back to `ST_COLSTB` for the next beat, or to `ST_IDLE` after beat 3.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset both strobes are high (inactive), no row is open, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request that finds no row open drops the row strobe with the row on the address bus for `T_RCD` cycles before the first column pulse. The first beat appears `1+T_RCD+T_CAS` clock edges after the edge that accepted the request. The column strobe is never low while the row strobe is high.
- R3: A block yields four beats in order, with `rd_beat` = 0,1,2,3. Beat k reads column `{blk, k}`, where the block number occupies the upper `COL_W-2` column bits and k the low two bits. `rd_last` is 1 only on beat 3.
- R4: Each column pulse is low for `T_CAS` cycles and is followed by `T_CP` high cycles. Consecutive beats of a block are therefore `T_CAS+T_CP` cycles apart.
- R5: A request whose row equals the open row makes no row-strobe transition. Its first beat appears `1+T_CAS` edges after acceptance, and `rd_hit` is 1 on all of its beats (0 otherwise).
- R6: A request to a different row while a row is open holds the row strobe high for exactly `T_RP` cycles and then opens the new row. Its first beat appears `1+T_RP+T_RCD+T_CAS` edges after acceptance.
- R7: After a block completes, the row strobe stays low (row open) while the controller is idle.
- R8: `dram_addr_c` is always the bitwise inverse of `dram_addr_t`.
- R9: `req_ready` is 0 while the buffer holds a request. A request accepted while another is being served is served afterwards, in arrival order.
- R10: `rd_data` equals `dram_dq` as sampled in the final low cycle of the corresponding column pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block-read request present |
| req_ready | output | 1 | Command buffer can accept |
| req_addr | input | ROW_W+COL_W-2 | {row, block} of the request |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_addr_t | output | max(ROW_W,COL_W) | Multiplexed address, true polarity |
| dram_addr_c | output | max(ROW_W,COL_W) | Multiplexed address, inverted |
| dram_dq | input | DQ_W | Read data from the array |
| rd_valid | output | 1 | Beat valid |
| rd_data | output | DQ_W | Beat data |
| rd_beat | output | 2 | Beat index within the block |
| rd_last | output | 1 | Final beat of the block |
| rd_hit | output | 1 | Block was served from the open row |

## Verification
The hardest case to reach is a request that waits in the buffer while the current block is still being read, whose row differs from the row that block left open. It must then pass through precharge even though it was queued behind a row hit. The bench first opens a row, then pushes a hit to that row and, in the very next cycle, a request to another row. This checks that `req_ready` is low, that the beats come out in arrival order, and that the second block's data carries the new row. The DRAM model latches the row at every falling row strobe. Wrong data after a hit, or a change in the count of falling row strobes, exposes a skipped or spurious row opening.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ROWOPEN,
        ST_COLSTB,
        ST_COLGAP
    } pgd_state_e;
endpackage

// File: rtl/pgd_timer.sv
module pgd_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R4: an interval counts down one per cycle until it expires
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pgd_cmdbuf.sv
module pgd_cmdbuf #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (push) begin
            full <= 1'b1;
            data <= push_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    // R9: a held entry is neither lost nor altered until taken
    p_entry_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(data)));
endmodule

// File: rtl/pgd_rowtrack.sv
module pgd_rowtrack #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_valid,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= 1'b0;
            open_row  <= '0;
        end else if (open_req) begin
            row_valid <= 1'b1;
            open_row  <= set_row;
        end else if (close_req) begin
            row_valid <= 1'b0;
        end
    end

    assign hit = row_valid && (open_row == cmp_row);

    // R7: an open row stays open and unchanged unless closed or reopened
    p_row_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !open_req && !close_req) |=> (row_valid && $stable(open_row)));
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgd_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    parameter int DQ_W  = 16,
    parameter int T_RCD = 2,
    parameter int T_CAS = 2,
    parameter int T_CP  = 1,
    parameter int T_RP  = 2,
    localparam int BLK_W = COL_W - 2,
    localparam int REQ_W = ROW_W + BLK_W,
    localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [REQ_W-1:0] req_addr,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic [AW-1:0]    dram_addr_t,
    output logic [AW-1:0]    dram_addr_c,
    input  logic [DQ_W-1:0]  dram_dq,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data,
    output logic [1:0]       rd_beat,
    output logic             rd_last,
    output logic             rd_hit
);
    localparam int TMAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TMAX2 = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TW    = (TMAX < 2) ? 1 : $clog2(TMAX);

    pgd_state_e       state_q, state_d;
    logic             buf_full, take, push;
    logic [REQ_W-1:0] buf_addr;
    logic [ROW_W-1:0] buf_row, cur_row, set_row;
    logic [BLK_W-1:0] buf_blk, cur_blk;
    logic [1:0]       beat_q;
    logic             cur_hit;
    logic             open_row, close_row, row_valid, hit;
    logic             tmr_load, tmr_done;
    logic [TW-1:0]    tmr_val;

    assign req_ready = !buf_full;
    assign push      = req_valid && req_ready;
    assign buf_row   = buf_addr[REQ_W-1:BLK_W];
    assign buf_blk   = buf_addr[BLK_W-1:0];
    assign set_row   = (state_q == ST_IDLE) ? buf_row : cur_row;

    pgd_cmdbuf #(.W(REQ_W)) u_cmdbuf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(req_addr),
        .pop(take), .full(buf_full), .data(buf_addr)
    );

    pgd_rowtrack #(.ROW_W(ROW_W)) u_rowtrack (
        .clk(clk), .rst_n(rst_n), .open_req(open_row), .close_req(close_row),
        .set_row(set_row), .cmp_row(buf_row), .row_valid(row_valid), .hit(hit)
    );

    pgd_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        open_row  = 1'b0;
        close_row = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_full) begin
                    take     = 1'b1;
                    tmr_load = 1'b1;
                    if (!row_valid) begin
                        state_d  = ST_ROWOPEN;
                        open_row = 1'b1;
                        tmr_val  = TW'(T_RCD - 1);
                    end else if (hit) begin
                        state_d = ST_COLSTB;
                        tmr_val = TW'(T_CAS - 1);
                    end else begin
                        state_d   = ST_PRECH;
                        close_row = 1'b1;
                        tmr_val   = TW'(T_RP - 1);
                    end
                end
            end
            ST_PRECH: begin
                if (tmr_done) begin
                    state_d  = ST_ROWOPEN;
                    open_row = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RCD - 1);
                end
            end
            ST_ROWOPEN: begin
                if (tmr_done) begin
                    state_d  = ST_COLSTB;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_CAS - 1);
                end
            end
            ST_COLSTB: begin
                if (tmr_done) begin
                    state_d  = ST_COLGAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_CP - 1);
                end
            end
            ST_COLGAP: begin
                if (tmr_done) begin
                    if (beat_q == 2'd3) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_COLSTB;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_CAS - 1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request context, beat counter and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row  <= '0;
            cur_blk  <= '0;
            cur_hit  <= 1'b0;
            beat_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_beat  <= '0;
            rd_last  <= 1'b0;
            rd_hit   <= 1'b0;
        end else begin
            if (take) begin
                cur_row <= buf_row;
                cur_blk <= buf_blk;
                cur_hit <= hit;
                beat_q  <= '0;
            end else if (state_q == ST_COLGAP && tmr_done && beat_q != 2'd3) begin
                beat_q <= beat_q + 2'd1;
            end
            rd_valid <= (state_q == ST_COLSTB) && tmr_done;
            if ((state_q == ST_COLSTB) && tmr_done) begin
                rd_data <= dram_dq;
                rd_beat <= beat_q;
                rd_last <= (beat_q == 2'd3);
                rd_hit  <= cur_hit;
            end
        end
    end

    // Outputs
    always_comb begin
        dram_ras_n = !row_valid;
        dram_cas_n = (state_q != ST_COLSTB);
        unique case (state_q)
            ST_ROWOPEN:           dram_addr_t = AW'(cur_row);
            ST_COLSTB, ST_COLGAP: dram_addr_t = AW'({cur_blk, beat_q});
            default:              dram_addr_t = '0;
        endcase
        dram_addr_c = ~dram_addr_t;
    end

    // R2: a column pulse only happens inside an open row
    p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R5: a hit goes straight to a column pulse with the row strobe untouched
    p_hit_skips_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && buf_full && row_valid && hit) |=> (!dram_ras_n && !dram_cas_n));

    // R6: the row strobe only rises when a precharge starts
    p_rise_is_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (state_q == ST_PRECH));

    // R10: every beat comes from a cycle with the column strobe low
    p_data_from_cas_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!dram_cas_n));
endmodule

// File: tb/pgdram_ctrl_tb.sv
module pgdram_ctrl_tb;
    localparam int ROW_W = 8, COL_W = 8, DQ_W = 16;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2;
    localparam int BLK_W = COL_W - 2;
    localparam int AW = 8;
    localparam logic [15:0] MASK = 16'hA5C3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ROW_W+BLK_W-1:0] req_addr = '0;
    logic req_ready, dram_ras_n, dram_cas_n;
    logic [AW-1:0] dram_addr_t, dram_addr_c;
    logic [DQ_W-1:0] dram_dq;
    logic rd_valid, rd_last, rd_hit;
    logic [DQ_W-1:0] rd_data;
    logic [1:0] rd_beat;

    always #4 clk = ~clk;

    pgdram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .T_RCD(T_RCD),
                  .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_addr_t(dram_addr_t), .dram_addr_c(dram_addr_c), .dram_dq(dram_dq),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat),
        .rd_last(rd_last), .rd_hit(rd_hit)
    );

    // DRAM model: latch row on falling row strobe, return {row, column} ^ MASK
    logic [ROW_W-1:0] model_row = '0;
    int ras_falls = 0;
    always @(negedge dram_ras_n) begin
        model_row = dram_addr_t[ROW_W-1:0];
        ras_falls++;
    end
    assign dram_dq = dram_cas_n ? '0 : ({model_row, dram_addr_t[COL_W-1:0]} ^ MASK);

    int tests = 0, fails = 0;
    int cyc = 0;
    int hi_run = 0, last_hi_run = 0, compl_bad = 0;
    int nbeat = 0;
    logic [DQ_W-1:0] b_data [64];
    logic [1:0] b_num [64];
    logic b_last [64], b_hit [64];
    int b_cyc [64];

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_ras_n) hi_run++;
            else begin
                if (hi_run != 0) last_hi_run = hi_run;
                hi_run = 0;
            end
            if (dram_addr_c !== ~dram_addr_t) compl_bad++;
            if (rd_valid && nbeat < 64) begin
                b_data[nbeat] = rd_data;
                b_num[nbeat]  = rd_beat;
                b_last[nbeat] = rd_last;
                b_hit[nbeat]  = rd_hit;
                b_cyc[nbeat]  = cyc;
                nbeat++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [7:0] row,
                                             input logic [5:0] blk, input int k);
        return {row, blk, 2'(k)} ^ MASK;
    endfunction

    // push one request; returns the cycle number of the accepting edge
    task automatic push_req(input logic [7:0] row, input logic [5:0] blk, output int pcyc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {row, blk};
        @(posedge clk);
        pcyc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_block(input int first, input logic [7:0] row,
                               input logic [5:0] blk, input bit exp_hit, input string req);
        while (nbeat < first + 4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk(b_data[first+k] == exp_word(row, blk, k), "R3/R10", {req, " beat data"},
                b_data[first+k], exp_word(row, blk, k));
            chk(b_num[first+k] == 2'(k), "R3", "beat index", b_num[first+k], k);
            chk(b_last[first+k] == (k == 3), "R3", "last flag", b_last[first+k], k == 3);
            chk(b_hit[first+k] == exp_hit, "R5", {req, " hit flag"}, b_hit[first+k], exp_hit);
            if (k > 0)
                chk(b_cyc[first+k] - b_cyc[first+k-1] == T_CAS + T_CP, "R4", "beat spacing",
                    b_cyc[first+k] - b_cyc[first+k-1], T_CAS + T_CP);
        end
    endtask

    task automatic t_reset;
        chk(dram_ras_n === 1'b1, "R1", "ras_n", dram_ras_n, 1);
        chk(dram_cas_n === 1'b1, "R1", "cas_n", dram_cas_n, 1);
        chk(req_ready === 1'b1, "R1", "ready", req_ready, 1);
        chk(rd_valid === 1'b0, "R1", "rd_valid", rd_valid, 0);
    endtask

    task automatic t_closed_row;
        int p, first, rf;
        first = nbeat; rf = ras_falls;
        push_req(8'h12, 6'h05, p);
        check_block(first, 8'h12, 6'h05, 1'b0, "R2");
        chk(b_cyc[first] - p == 1 + T_RCD + T_CAS, "R2", "closed-row latency",
            b_cyc[first] - p, 1 + T_RCD + T_CAS);
        chk(ras_falls - rf == 1, "R2", "row openings", ras_falls - rf, 1);
        repeat (5) @(negedge clk);
        chk(dram_ras_n === 1'b0, "R7", "row stays open", dram_ras_n, 0);
    endtask

    task automatic t_hit;
        int p, first, rf;
        first = nbeat; rf = ras_falls;
        push_req(8'h12, 6'h3A, p);
        check_block(first, 8'h12, 6'h3A, 1'b1, "R5");
        chk(b_cyc[first] - p == 1 + T_CAS, "R5", "hit latency", b_cyc[first] - p, 1 + T_CAS);
        chk(ras_falls - rf == 0, "R5", "no row strobe", ras_falls - rf, 0);
    endtask

    task automatic t_miss;
        int p, first, rf;
        first = nbeat; rf = ras_falls;
        repeat (3) @(negedge clk);
        push_req(8'h40, 6'h01, p);
        check_block(first, 8'h40, 6'h01, 1'b0, "R6");
        chk(b_cyc[first] - p == 1 + T_RP + T_RCD + T_CAS, "R6", "miss latency",
            b_cyc[first] - p, 1 + T_RP + T_RCD + T_CAS);
        chk(last_hi_run == T_RP, "R6", "precharge length", last_hi_run, T_RP);
        chk(ras_falls - rf == 1, "R6", "row openings", ras_falls - rf, 1);
    endtask

    task automatic t_queued;
        int p, first, rf;
        first = nbeat; rf = ras_falls;
        push_req(8'h40, 6'h10, p);
        chk(req_ready === 1'b0, "R9", "ready while held", req_ready, 0);
        push_req(8'h77, 6'h2F, p);
        check_block(first, 8'h40, 6'h10, 1'b1, "R9 first");
        check_block(first + 4, 8'h77, 6'h2F, 1'b0, "R9 second");
        chk(ras_falls - rf == 1, "R9", "row openings", ras_falls - rf, 1);
        chk(last_hi_run == T_RP, "R6", "queued precharge", last_hi_run, T_RP);
    endtask

    task automatic t_top_block;
        int p, first;
        first = nbeat;
        push_req(8'h77, 6'h3F, p);
        check_block(first, 8'h77, 6'h3F, 1'b1, "R3 top block");
        chk(compl_bad == 0, "R8", "complement mismatches", compl_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_closed_row();
        t_hit();
        t_miss();
        t_queued();
        t_top_block();
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule